// File: doc/BRIEF.md
# Single-Level Page Translation Unit

This unit turns a 32-bit logical address into a physical address. It uses one page table held in memory. Pages are 4 KB. The low 12 address bits form the in-page offset and the upper 20 bits form the page number. A context register holds the table's base byte address and its length in entries. Software loads both values at the same moment, through a one-cycle load strobe, whenever a new address space becomes active.

For each accepted request, the unit first compares the page number against the table length. A page past the end of the table faults straight away and no memory read is made. A page inside the table produces one word read at `base + page*4` on a simple request/response memory port. The returned entry holds a 20-bit frame number in bits 31:12 and a 2-bit access mode in bits 1:0. The mode is checked against the request kind. If the access is allowed, the frame number is joined with the unchanged offset. Otherwise a fault code is returned. Only one translation is in flight at a time, and requests and responses use valid/ready handshakes.

Top module: `pgx_top`

## Requirements
- R1: After reset, `reqReady` is 1 and `rspValid` and `memReqValid` are 0. The context length is 0, so any request before the first context load ends with fault code 1 and makes no memory read.
- R2: For a page number below the table length, exactly one memory read is issued. Its byte address is the context base plus four times the page number (address bits 31:12).
- R3: A page number greater than or equal to the table length ends with fault code 1 (out of range) and issues no memory read. A page number equal to the length minus one is still translated.
- R4: An allowed access returns fault code 0. The physical address is entry bits 31:12 followed by request address bits 11:0.
- R5: The request kind is 2'b00 read, 2'b01 write, 2'b10 instruction fetch, and 2'b11 is judged as a write. Entry mode 2'b00 (read-write) allows every kind. Mode 2'b01 (read-only) faults writes with code 2. Mode 2'b10 (execute-only) allows only fetches and faults reads and writes with code 2.
- R6: Entry mode 2'b11 is reserved. It ends every request kind with fault code 3.
- R7: Every response with a nonzero fault code carries physical address 0.
- R8: `reqReady` stays 0 from the cycle after a request is accepted until the cycle after its response is taken.
- R9: While `rspValid` is 1 and `rspReady` is 0, the response stays valid and its address and fault code do not change.
- R10: If a context load and a request acceptance fall in the same cycle, that request uses the previous base and length. The new context applies from the next request on.
- R11: While `memReqValid` is 1 and `memReqReady` is 0, the memory request stays valid and its address does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctxLoad | input | 1 | Load strobe for the context register |
| ctxBase | input | 32 | Page-table base byte address to load |
| ctxLen | input | 21 | Page-table length in entries to load |
| reqValid | input | 1 | Translation request valid |
| reqReady | output | 1 | Unit can accept a request |
| reqAddr | input | 32 | Logical address |
| reqKind | input | 2 | Access kind: 00 read, 01 write, 10 fetch, 11 write |
| memReqValid | output | 1 | Page-table read request valid |
| memReqReady | input | 1 | Memory accepts the read |
| memReqAddr | output | 32 | Byte address of the page-table entry |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 32 | Page-table entry |
| rspValid | output | 1 | Translation result valid |
| rspReady | input | 1 | Consumer takes the result |
| rspPhysAddr | output | 32 | Physical address, 0 on fault |
| rspFault | output | 2 | 0 none, 1 out of range, 2 protection, 3 reserved mode |

## Verification
A context load and a request acceptance can land on the same clock edge. The question is then which base and length the bounds check and the entry address see. The bench raises the load strobe with a shorter table and a new base in the same cycle as a request whose page fits only the old table. It expects the read at the old base and a clean translation. It then sends the same page again and expects an out-of-range fault. A last request is expected to read from the new base.

// File: rtl/pgx_pkg.sv
package pgx_pkg;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_RANGE = 2'd1,
    FLT_PROT  = 2'd2,
    FLT_RSVD  = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    ACC_RW   = 2'd0,
    ACC_RO   = 2'd1,
    ACC_XO   = 2'd2,
    ACC_RSVD = 2'd3
  } acc_e;

  // control -> datapath strobes
  typedef struct packed {
    logic accept;      // request taken this cycle
    logic rangeFault;  // page beyond table, with accept
    logic capture;     // entry returned this cycle
  } strobe_t;

  // kind: 00 read, 01 write, 10 fetch, 11 treated as write
  function automatic fault_e judgeAccess(logic [1:0] acc, logic [1:0] kind);
    fault_e res;
    case (acc)
      ACC_RW:  res = FLT_NONE;
      ACC_RO:  res = kind[0] ? FLT_PROT : FLT_NONE;
      ACC_XO:  res = (kind == 2'b10) ? FLT_NONE : FLT_PROT;
      default: res = FLT_RSVD;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/pgx_ctrl.sv
module pgx_ctrl
  import pgx_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    inRange,
  input  logic    memReqReady,
  input  logic    memRspValid,
  input  logic    rspReady,
  output logic    reqReady,
  output logic    memReqValid,
  output logic    rspValid,
  output strobe_t stb
);

  typedef enum logic [1:0] {ST_IDLE, ST_MREQ, ST_MWAIT, ST_RESP} state_e;

  state_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext   = state;
    stb         = '0;
    reqReady    = 1'b0;
    memReqValid = 1'b0;
    rspValid    = 1'b0;
    case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          stb.accept = 1'b1;
          if (inRange) begin
            stateNext = ST_MREQ;
          end else begin
            stb.rangeFault = 1'b1;
            stateNext      = ST_RESP;
          end
        end
      end
      ST_MREQ: begin
        memReqValid = 1'b1;
        if (memReqReady) stateNext = ST_MWAIT;
      end
      ST_MWAIT: begin
        if (memRspValid) begin
          stb.capture = 1'b1;
          stateNext   = ST_RESP;
        end
      end
      default: begin
        rspValid = 1'b1;
        if (rspReady) stateNext = ST_IDLE;
      end
    endcase
  end

endmodule

// File: rtl/pgx_dpath.sv
module pgx_dpath
  import pgx_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int OFF_W     = 12,
  parameter int PTE_SHIFT = 2,
  localparam int PAGE_W   = ADDR_W - OFF_W,
  localparam int LEN_W    = PAGE_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctxLoad,
  input  logic [ADDR_W-1:0] ctxBase,
  input  logic [LEN_W-1:0]  ctxLen,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqKind,
  input  logic [ADDR_W-1:0] memRspData,
  input  strobe_t           stb,
  output logic              inRange,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [ADDR_W-1:0] rspPhysAddr,
  output logic [1:0]        rspFault
);

  logic [ADDR_W-1:0] baseQ;
  logic [LEN_W-1:0]  lenQ;
  logic [OFF_W-1:0]  offQ;
  logic [1:0]        kindQ;
  logic [PAGE_W-1:0] pageNum;
  logic [PAGE_W-1:0] frameNum;
  logic [1:0]        accBits;
  fault_e            entryFault;
  logic              unusedBits;

  assign pageNum    = reqAddr[ADDR_W-1:OFF_W];
  assign inRange    = {1'b0, pageNum} < lenQ;
  assign frameNum   = memRspData[ADDR_W-1:OFF_W];
  assign accBits    = memRspData[1:0];
  assign entryFault = judgeAccess(accBits, kindQ);
  assign unusedBits = ^memRspData[OFF_W-1:2];

  // context register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= '0;
      lenQ  <= '0;
    end else if (ctxLoad) begin
      baseQ <= ctxBase;
      lenQ  <= ctxLen;
    end
  end

  // request capture and entry address
  always_ff @(posedge clk) begin
    if (!rstN) begin
      offQ       <= '0;
      kindQ      <= '0;
      memReqAddr <= '0;
    end else if (stb.accept) begin
      offQ       <= reqAddr[OFF_W-1:0];
      kindQ      <= reqKind;
      memReqAddr <= baseQ + (ADDR_W'(pageNum) << PTE_SHIFT);
    end
  end

  // result register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspPhysAddr <= '0;
      rspFault    <= FLT_NONE;
    end else if (stb.accept && stb.rangeFault) begin
      rspPhysAddr <= '0;
      rspFault    <= FLT_RANGE;
    end else if (stb.capture) begin
      rspFault    <= entryFault;
      rspPhysAddr <= (entryFault == FLT_NONE) ? {frameNum, offQ} : '0;
    end
  end

endmodule

// File: rtl/pgx_top.sv
module pgx_top
  import pgx_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int OFF_W     = 12,
  parameter int PTE_SHIFT = 2,
  localparam int LEN_W    = ADDR_W - OFF_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctxLoad,
  input  logic [ADDR_W-1:0] ctxBase,
  input  logic [LEN_W-1:0]  ctxLen,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqKind,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [ADDR_W-1:0] memRspData,
  output logic              rspValid,
  input  logic              rspReady,
  output logic [ADDR_W-1:0] rspPhysAddr,
  output logic [1:0]        rspFault
);

  strobe_t stb;
  logic    inRange;

  pgx_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .inRange     (inRange),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .rspReady    (rspReady),
    .reqReady    (reqReady),
    .memReqValid (memReqValid),
    .rspValid    (rspValid),
    .stb         (stb)
  );

  pgx_dpath #(
    .ADDR_W    (ADDR_W),
    .OFF_W     (OFF_W),
    .PTE_SHIFT (PTE_SHIFT)
  ) dpath_i (
    .clk         (clk),
    .rstN        (rstN),
    .ctxLoad     (ctxLoad),
    .ctxBase     (ctxBase),
    .ctxLen      (ctxLen),
    .reqAddr     (reqAddr),
    .reqKind     (reqKind),
    .memRspData  (memRspData),
    .stb         (stb),
    .inRange     (inRange),
    .memReqAddr  (memReqAddr),
    .rspPhysAddr (rspPhysAddr),
    .rspFault    (rspFault)
  );

endmodule

// File: rtl/pgx_checker.sv
module pgx_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              rspValid,
  input logic              rspReady,
  input logic [ADDR_W-1:0] rspPhysAddr,
  input logic [1:0]        rspFault
);

  p_rsp_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !reqReady);

  p_mem_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !reqReady);

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=>
      (rspValid && $stable(rspPhysAddr) && $stable(rspFault)));

  p_fault_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault != 2'd0) |-> (rspPhysAddr == '0));

  p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr)));

  p_one_side_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(memReqValid && rspValid));

endmodule

bind pgx_top pgx_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .reqReady    (reqReady),
  .memReqValid (memReqValid),
  .memReqReady (memReqReady),
  .memReqAddr  (memReqAddr),
  .rspValid    (rspValid),
  .rspReady    (rspReady),
  .rspPhysAddr (rspPhysAddr),
  .rspFault    (rspFault)
);

// File: tb/pgx_top_tb_top.sv
`timescale 1ns/1ps
module pgx_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctxLoad = 1'b0;
  logic [31:0] ctxBase = '0;
  logic [20:0] ctxLen = '0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqAddr = '0;
  logic [1:0]  reqKind = '0;
  logic        memReqValid;
  logic        memReqReady = 1'b1;
  logic [31:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic        rspValid;
  logic        rspReady = 1'b1;
  logic [31:0] rspPhysAddr;
  logic [1:0]  rspFault;

  int compared = 0;
  int mismatched = 0;
  int readCount = 0;
  logic [31:0] lastMemAddr = '0;
  logic        pendQ = 1'b0;
  logic [31:0] pendAddr = '0;
  logic [31:0] pt [logic [31:0]];

  logic        stageCtx = 1'b0;
  logic [31:0] stageBase = '0;
  logic [20:0] stageLen = '0;

  logic [31:0] gPhys;
  logic [1:0]  gFault;
  int          gReads;
  logic [31:0] gMemAddr;

  always #2 clk = ~clk;

  pgx_top dut_i (
    .clk(clk), .rstN(rstN), .ctxLoad(ctxLoad), .ctxBase(ctxBase), .ctxLen(ctxLen),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr), .reqKind(reqKind),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .rspValid(rspValid), .rspReady(rspReady), .rspPhysAddr(rspPhysAddr), .rspFault(rspFault)
  );

  function automatic logic [31:0] lookup(logic [31:0] a);
    return pt.exists(a) ? pt[a] : 32'h0;
  endfunction

  // page-table memory: one-cycle accept, response two edges later
  always @(posedge clk) begin
    if (memReqValid && memReqReady) begin
      readCount++;
      lastMemAddr = memReqAddr;
    end
    memRspValid <= pendQ;
    memRspData  <= lookup(pendAddr);
    pendQ       <= memReqValid && memReqReady;
    pendAddr    <= memReqAddr;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic loadCtx(logic [31:0] b, logic [20:0] l);
    @(negedge clk);
    ctxLoad = 1'b1; ctxBase = b; ctxLen = l;
    @(negedge clk);
    ctxLoad = 1'b0;
  endtask

  task automatic xlate(logic [31:0] addr, logic [1:0] kind, int rspHold, int memStall);
    int startReads;
    int t;
    logic [31:0] a0;
    @(negedge clk);
    startReads  = readCount;
    memReqReady = (memStall == 0);
    rspReady    = (rspHold == 0);
    reqAddr = addr; reqKind = kind; reqValid = 1'b1;
    if (stageCtx) begin
      ctxLoad = 1'b1; ctxBase = stageBase; ctxLen = stageLen;
    end
    @(negedge clk);
    reqValid = 1'b0;
    ctxLoad  = 1'b0;
    stageCtx = 1'b0;
    if (memStall > 0) begin
      a0 = memReqAddr;
      for (int k = 0; k < memStall; k++) begin
        chk("R11 memReqValid held", {31'b0, memReqValid}, 32'd1);
        chk("R11 memReqAddr stable", memReqAddr, a0);
        chk("R8 reqReady low during read", {31'b0, reqReady}, 32'd0);
        @(negedge clk);
      end
      memReqReady = 1'b1;
    end
    t = 0;
    while (!rspValid && t < 100) begin
      @(negedge clk);
      t++;
    end
    chk("R8 response arrives", {31'b0, rspValid}, 32'd1);
    gPhys  = rspPhysAddr;
    gFault = rspFault;
    if (rspHold > 0) begin
      for (int k = 0; k < rspHold; k++) begin
        @(negedge clk);
        chk("R9 rspValid held", {31'b0, rspValid}, 32'd1);
        chk("R9 rspPhysAddr stable", rspPhysAddr, gPhys);
        chk("R9 rspFault stable", {30'b0, rspFault}, {30'b0, gFault});
        chk("R8 reqReady low while held", {31'b0, reqReady}, 32'd0);
      end
      rspReady = 1'b1;
    end
    @(negedge clk);
    chk("R8 reqReady back after take", {31'b0, reqReady}, 32'd1);
    gReads   = readCount - startReads;
    gMemAddr = lastMemAddr;
  endtask

  task automatic expectOk(string req, logic [31:0] phys, logic [31:0] memAddr);
    chk({req, " fault"}, {30'b0, gFault}, 32'd0);
    chk({req, " phys"}, gPhys, phys);
    chk({req, " one read"}, gReads, 32'd1);
    chk({req, " entry addr"}, gMemAddr, memAddr);
  endtask

  task automatic expectFault(string req, logic [1:0] code, int reads);
    chk({req, " fault code"}, {30'b0, gFault}, {30'b0, code});
    chk("R7 phys zero on fault", gPhys, 32'h0);
    chk({req, " reads"}, gReads, reads);
  endtask

  task automatic testReset();
    chk("R1 reqReady", {31'b0, reqReady}, 32'd1);
    chk("R1 rspValid", {31'b0, rspValid}, 32'd0);
    chk("R1 memReqValid", {31'b0, memReqValid}, 32'd0);
    xlate(32'h0000_0abc, 2'b00, 0, 0);
    expectFault("R1 empty table", 2'd1, 0);
  endtask

  task automatic testBasic();
    xlate(32'h0000_0123, 2'b00, 0, 0);
    expectOk("R4 R2 page0 read", 32'hABCD_E123, 32'h0010_0000);
    xlate(32'h0000_FFFF, 2'b01, 0, 0);
    expectOk("R4 R2 last page write", 32'hFFFF_FFFF, 32'h0010_003C);
  endtask

  task automatic testRange();
    xlate(32'h0001_0000, 2'b00, 0, 0);
    expectFault("R3 page equals length", 2'd1, 0);
    xlate(32'hFFFF_F004, 2'b10, 0, 0);
    expectFault("R3 top page", 2'd1, 0);
  endtask

  task automatic testProt();
    xlate(32'h0000_3010, 2'b01, 0, 0);
    expectFault("R5 write read-only", 2'd2, 1);
    xlate(32'h0000_3010, 2'b00, 0, 0);
    expectOk("R5 read read-only", 32'h1234_5010, 32'h0010_000C);
    xlate(32'h0000_3020, 2'b11, 0, 0);
    expectFault("R5 kind 11 on read-only", 2'd2, 1);
    xlate(32'h0000_5abc, 2'b00, 0, 0);
    expectFault("R5 read execute-only", 2'd2, 1);
    xlate(32'h0000_5abc, 2'b01, 0, 0);
    expectFault("R5 write execute-only", 2'd2, 1);
    xlate(32'h0000_5abc, 2'b10, 0, 0);
    expectOk("R5 fetch execute-only", 32'h0077_7abc, 32'h0010_0014);
    xlate(32'h0000_0800, 2'b10, 0, 0);
    expectOk("R5 fetch read-write", 32'hABCD_E800, 32'h0010_0000);
  endtask

  task automatic testReserved();
    xlate(32'h0000_7000, 2'b00, 0, 0);
    expectFault("R6 reserved read", 2'd3, 1);
    xlate(32'h0000_7000, 2'b10, 0, 0);
    expectFault("R6 reserved fetch", 2'd3, 1);
  endtask

  task automatic testBackpressure();
    xlate(32'h0000_0456, 2'b00, 3, 0);
    expectOk("R9 held response", 32'hABCD_E456, 32'h0010_0000);
    xlate(32'h0000_3fff, 2'b00, 0, 3);
    expectOk("R11 stalled read", 32'h1234_5fff, 32'h0010_000C);
    xlate(32'h0002_0000, 2'b00, 2, 0);
    expectFault("R9 held range fault", 2'd1, 0);
  endtask

  task automatic testCtxSameCycle();
    stageCtx = 1'b1; stageBase = 32'h0020_0000; stageLen = 21'd2;
    xlate(32'h0000_3111, 2'b00, 0, 0);
    expectOk("R10 old context used", 32'h1234_5111, 32'h0010_000C);
    xlate(32'h0000_3111, 2'b00, 0, 0);
    expectFault("R10 new length applies", 2'd1, 0);
    xlate(32'h0000_1222, 2'b01, 0, 0);
    expectOk("R10 new base applies", 32'h0BEE_F222, 32'h0020_0004);
  endtask

  initial begin
    pt[32'h0010_0000] = 32'hABCD_E000;  // page 0 read-write
    pt[32'h0010_000C] = 32'h1234_5001;  // page 3 read-only
    pt[32'h0010_0014] = 32'h0077_7002;  // page 5 execute-only
    pt[32'h0010_001C] = 32'h5555_5003;  // page 7 reserved mode
    pt[32'h0010_003C] = 32'hFFFF_F000;  // page 15 read-write
    pt[32'h0020_0004] = 32'h0BEE_F000;  // new table page 1 read-write
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    loadCtx(32'h0010_0000, 21'd16);
    testBasic();
    testRange();
    testProt();
    testReserved();
    testBackpressure();
    testCtxSameCycle();
    repeat (2) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule